// File: doc/BRIEF.md
# Round-Robin Serial ADC Sampler

This block is a receive-only serial master that keeps a bank of external serial ADCs sampled without software involvement. Once enabled it walks through the channels in a fixed circular order: for each channel it asserts the matching select pattern, clocks in one conversion frame MSB first from a single data input shared by every converter, and stores the result in that channel's result register. A fresh-data flag marks each register until it is read.

A two-bit framing setting picks the attached converter family. The quad framing takes 12-bit samples from one four-channel device whose channel inputs are driven straight from two select lines. The two single-channel framings take 15-bit or 16-bit samples from up to eight converters, with the channel index sent as a binary code to an external 3-to-8 decoder. The serial clock rate, the idle time between frames and the highest channel index in the loop are all settable. These settings are meant to be changed only while the loop is stopped.

Top module: `rr_adc_sampler`

## Requirements
- R1: Out of reset `sclk` is high, all eight `csLines` are high, and every channel reads back `rdValid`=0 and `rdData`=0.
- R2: One cycle after `enable` is seen low, `csLines` are all high and `sclk` is high; a frame cut short this way stores nothing, and the next run starts again at channel 0.
- R3: During a frame each low and each high phase of `sclk` lasts max(`clkDiv`,1) system clocks; a frame begins with `sclk` falling as the selects go active, `sdi` is taken on each rising edge of `sclk`, MSB first, and `sclk` stays high whenever no channel is selected.
- R4: A frame has exactly 12 rising `sclk` edges when `modeSel`=0, 15 when `modeSel`=1, and 16 when `modeSel` is 2 or 3.
- R5: With `modeSel`=0, during a frame `csLines[1:0]` carry the channel number, `csLines[2]` is low, and `csLines[7:3]` are high.
- R6: With `modeSel` not 0, during a frame `csLines[2:0]` carry the channel number in binary, `csLines[3]` is low (decoder enable), and `csLines[7:4]` are high.
- R7: Channels are visited 0, 1, 2, … up to `chanCount` and then wrap to 0; with `modeSel`=0 the last channel is min(`chanCount`,3).
- R8: Between two frames of a run all `csLines` stay high for exactly 2·max(`idleGap`,1)·max(`clkDiv`,1) system clocks.
- R9: When a frame ends, the bits received are stored right-aligned in that channel's 16-bit result with the unused upper bits zero, readable in the same cycle the selects go inactive.
- R10: `rdData`/`rdValid` show the result and fresh flag of channel `rdAddr` without delay; a frame end sets that channel's flag, and `rdEn` high at a clock edge clears the flag of `rdAddr`.
- R11: If a read of a channel and the end of that channel's frame fall on the same clock edge, the flag stays set and the new sample is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous-free active-low reset, sampled on `clk` |
| enable | input | 1 | Runs the round-robin loop while high |
| modeSel | input | 2 | Framing: 0 quad 12-bit, 1 single 15-bit, 2/3 single 16-bit |
| chanCount | input | 3 | Highest channel index visited |
| clkDiv | input | 8 | Serial clock half period in system clocks (0 acts as 1) |
| idleGap | input | 4 | Idle time between frames in serial clock periods (0 acts as 1) |
| sdi | input | 1 | Shared serial data from all converters |
| rdEn | input | 1 | Read strobe, clears the fresh flag of `rdAddr` |
| rdAddr | input | 3 | Channel whose result is shown |
| rdData | output | 16 | Result of channel `rdAddr` |
| rdValid | output | 1 | Fresh flag of channel `rdAddr` |
| sclk | output | 1 | Serial clock to the converters |
| csLines | output | 8 | Select lines, encoding set by `modeSel` |

## Verification
The two functions that can meet in one cycle are the read-clear of a channel's fresh flag and the frame-end capture that sets it. The bench waits for the last rising serial clock edge of a frame, counts the known half period forward and drives a read of that same channel so it lands on the capture edge; its reference model applies the clear before the set, so it expects the flag to remain high with the new sample, and a later plain read must then clear it. Aborting a frame by dropping `enable` is also placed against the capture path to show that a partial frame never reaches a result register.

// File: rtl/rrAdcPkg.sv
package rrAdcPkg;

  typedef enum logic [1:0] {
    MODE_Q12    = 2'd0,
    MODE_S15    = 2'd1,
    MODE_S16    = 2'd2,
    MODE_S16ALT = 2'd3
  } adcMode_t;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_GAP  = 2'd1,
    ST_XFER = 2'd2
  } seqState_t;

  // strobes from the sequencer to the capture datapath
  typedef struct packed {
    logic clearShift;
    logic sampleBit;
    logic frameDone;
  } seqStrobe_t;

endpackage

// File: rtl/rrAdcCtrl.sv
module rrAdcCtrl
  import rrAdcPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 4,
  parameter int W_Q12  = 12,
  parameter int W_S15  = 15,
  parameter int W_S16  = 16,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int BIT_W   = $clog2(W_S16),
  localparam int GCNT_W  = GAP_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  adcMode_t          mode,
  input  logic [CH_W-1:0]   chanCount,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [GAP_W-1:0]  idleGap,
  output seqStrobe_t        stb,
  output logic [CH_W-1:0]   chan,
  output logic              sclk,
  output logic [NUM_CH-1:0] csLines
);

  localparam logic [CH_W-1:0] QUAD_LAST = CH_W'(3);

  seqState_t         state;
  logic [DIV_W-1:0]  divCnt;
  logic [GCNT_W-1:0] gapLeft;
  logic [BIT_W-1:0]  bitIdx;
  logic              phase;
  logic              sclkQ;

  logic [DIV_W-1:0]  halfLim;
  logic              tick;
  logic [BIT_W-1:0]  lastBit;
  logic [CH_W-1:0]   lastCh;
  logic [GAP_W-1:0]  effGap;
  logic [GCNT_W-1:0] gapTicks;

  always_comb begin
    halfLim  = (clkDiv == '0) ? DIV_W'(1) : clkDiv;
    tick     = (divCnt == halfLim - DIV_W'(1));
    effGap   = (idleGap == '0) ? GAP_W'(1) : idleGap;
    gapTicks = {effGap, 1'b0};
    unique case (mode)
      MODE_Q12: lastBit = BIT_W'(W_Q12 - 1);
      MODE_S15: lastBit = BIT_W'(W_S15 - 1);
      default:  lastBit = BIT_W'(W_S16 - 1);
    endcase
    lastCh = (mode == MODE_Q12 && chanCount > QUAD_LAST) ? QUAD_LAST : chanCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_OFF;
      divCnt  <= '0;
      gapLeft <= '0;
      bitIdx  <= '0;
      phase   <= 1'b0;
      chan    <= '0;
      sclkQ   <= 1'b1;
    end else if (!enable) begin
      state  <= ST_OFF;
      divCnt <= '0;
      bitIdx <= '0;
      phase  <= 1'b0;
      chan   <= '0;
      sclkQ  <= 1'b1;
    end else begin
      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      unique case (state)
        ST_OFF: begin
          state   <= ST_GAP;
          gapLeft <= gapTicks;
          divCnt  <= '0;
        end
        ST_GAP: begin
          if (tick) begin
            if (gapLeft == GCNT_W'(1)) begin
              state  <= ST_XFER;
              sclkQ  <= 1'b0;
              phase  <= 1'b0;
              bitIdx <= '0;
            end else begin
              gapLeft <= gapLeft - GCNT_W'(1);
            end
          end
        end
        ST_XFER: begin
          if (tick) begin
            if (!phase) begin
              sclkQ <= 1'b1;
              phase <= 1'b1;
            end else if (bitIdx == lastBit) begin
              state   <= ST_GAP;
              gapLeft <= gapTicks;
              phase   <= 1'b0;
              chan    <= (chan == lastCh) ? '0 : chan + CH_W'(1);
            end else begin
              bitIdx <= bitIdx + BIT_W'(1);
              phase  <= 1'b0;
              sclkQ  <= 1'b0;
            end
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  always_comb begin
    stb.clearShift = enable && (state == ST_GAP) && tick && (gapLeft == GCNT_W'(1));
    stb.sampleBit  = enable && (state == ST_XFER) && tick && !phase;
    stb.frameDone  = enable && (state == ST_XFER) && tick && phase && (bitIdx == lastBit);
  end

  // select encoding: direct channel lines for the quad device, binary code
  // plus an active-low decoder enable for single-channel devices
  always_comb begin
    csLines = '1;
    if (state == ST_XFER) begin
      if (mode == MODE_Q12) begin
        csLines[1:0] = chan[1:0];
        csLines[2]   = 1'b0;
      end else begin
        csLines[CH_W-1:0] = chan;
        csLines[CH_W]     = 1'b0;
      end
    end
  end

  assign sclk = sclkQ;

endmodule

// File: rtl/rrAdcDatapath.sv
module rrAdcDatapath
  import rrAdcPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic [CH_W-1:0]  chan,
  input  logic             sdi,
  input  logic             rdEn,
  input  logic [CH_W-1:0]  rdAddr,
  output logic [RES_W-1:0] rdData,
  output logic             rdValid
);

  logic [RES_W-1:0] shiftReg;
  logic [RES_W-1:0] resArr  [NUM_CH];
  logic [NUM_CH-1:0] freshFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.clearShift) begin
      shiftReg <= '0;
    end else if (stb.sampleBit) begin
      shiftReg <= {shiftReg[RES_W-2:0], sdi};
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        resArr[g]    <= '0;
        freshFlag[g] <= 1'b0;
      end else begin
        if (rdEn && rdAddr == CH_W'(g)) freshFlag[g] <= 1'b0;
        if (stb.frameDone && chan == CH_W'(g)) begin
          resArr[g]    <= shiftReg;
          freshFlag[g] <= 1'b1;
        end
      end
    end
  end

  assign rdData  = resArr[rdAddr];
  assign rdValid = freshFlag[rdAddr];

endmodule

// File: rtl/rr_adc_sampler.sv
module rr_adc_sampler
  import rrAdcPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 16,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        modeSel,
  input  logic [CH_W-1:0]   chanCount,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [GAP_W-1:0]  idleGap,
  input  logic              sdi,
  input  logic              rdEn,
  input  logic [CH_W-1:0]   rdAddr,
  output logic [RES_W-1:0]  rdData,
  output logic              rdValid,
  output logic              sclk,
  output logic [NUM_CH-1:0] csLines
);

  seqStrobe_t      stb;
  logic [CH_W-1:0] curChan;

  rrAdcCtrl #(
    .NUM_CH(NUM_CH), .DIV_W(DIV_W), .GAP_W(GAP_W), .W_S16(RES_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(adcMode_t'(modeSel)),
    .chanCount(chanCount), .clkDiv(clkDiv), .idleGap(idleGap),
    .stb(stb), .chan(curChan), .sclk(sclk), .csLines(csLines)
  );

  rrAdcDatapath #(
    .NUM_CH(NUM_CH), .RES_W(RES_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .chan(curChan), .sdi(sdi),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/rrAdcChecker.sv
module rrAdcChecker #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [1:0]        modeSel,
  input logic [CH_W-1:0]   chanCount,
  input logic [CH_W-1:0]   rdAddr,
  input logic              rdValid,
  input logic              sclk,
  input logic [NUM_CH-1:0] csLines
);

  logic selActive;
  assign selActive = (csLines != '1);

  // R2: loop stopped one cycle after enable is low
  a_r2_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!selActive && sclk));

  // R3: serial clock parks high when nothing is selected
  a_r3_sclk_parks_high: assert property (@(posedge clk) disable iff (!rstN)
    !selActive |-> sclk);

  // R5: quad framing select pattern
  a_r5_quad_select_pattern: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd0 && selActive) |->
      (csLines[NUM_CH-1:2] == {{(NUM_CH-3){1'b1}}, 1'b0}));

  // R6: decoder framing select pattern
  a_r6_decoder_pattern: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != 2'd0 && selActive) |->
      (csLines[NUM_CH-1:CH_W] == {{(NUM_CH-CH_W-1){1'b1}}, 1'b0}));

  // R7: coded channel never beyond the last enabled index
  a_r7_index_bound: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != 2'd0 && selActive) |-> (csLines[CH_W-1:0] <= chanCount));

  // R10: a fresh flag only appears as a frame closes
  a_r10_flag_rises_on_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rdValid) && $stable(rdAddr)) |-> ($past(selActive) && !selActive));

endmodule

bind rr_adc_sampler rrAdcChecker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
  .chanCount(chanCount), .rdAddr(rdAddr), .rdValid(rdValid),
  .sclk(sclk), .csLines(csLines)
);

// File: tb/test_rr_adc_sampler.sv
module test_rr_adc_sampler;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  modeSel = 2'd2;
  logic [2:0]  chanCount = 3'd0;
  logic [7:0]  clkDiv = 8'd1;
  logic [3:0]  idleGap = 4'd1;
  logic        sdi = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  rdAddr = 3'd0;
  logic [15:0] rdData;
  logic        rdValid;
  logic        sclk;
  logic [7:0]  csLines;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_adc_sampler i_rr_adc_sampler (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .chanCount(chanCount), .clkDiv(clkDiv), .idleGap(idleGap), .sdi(sdi),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
    .sclk(sclk), .csLines(csLines)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int widthOf(input logic [1:0] m);
    return (m == 2'd0) ? 12 : (m == 2'd1) ? 15 : 16;
  endfunction

  function automatic int lastOf(input logic [1:0] m, input logic [2:0] cc);
    if (m == 2'd0 && cc > 3) return 3;
    return int'(cc);
  endfunction

  function automatic int halfOf(input logic [7:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  function automatic int frameValue(input int ch, input int n, input int w);
    int v;
    v = (ch * 32'h1357) ^ (n * 32'h2b1) ^ 32'ha5c3 ^ (n << 11);
    return v & ((1 << w) - 1);
  endfunction

  // reference model state
  int  expRes  [8];
  bit  expFlag [8];
  int  expCh = 0;
  bit  prevActive = 0;
  logic prevSclk = 1'b1;
  int  riseCnt = 0;
  int  runLen = 0;
  int  frameCh = 0;
  int  frameVal = 0;
  int  bitK = 0;
  int  gapCnt = 0;
  bit  gapValid = 0;
  bit  rdEnSeen = 0;
  int  rdAddrSeen = 0;
  bit  enSeen = 0;
  int  framesDone = 0;
  int  framesStarted = 0;

  always @(negedge clk) begin
    bit active;
    int w, h;
    active = (csLines != 8'hFF);
    w = widthOf(modeSel);
    h = halfOf(clkDiv);
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin expRes[i] = 0; expFlag[i] = 0; end
      expCh = 0; prevActive = 0; prevSclk = 1'b1; gapValid = 0;
      rdEnSeen = 0; enSeen = 0;
    end else begin
      if (rdEnSeen) expFlag[rdAddrSeen] = 0;
      if (!enSeen) begin
        chk(!active && sclk, "R2 stopped loop idles", {csLines, sclk}, {8'hFF, 1'b1});
        expCh = 0;
        gapValid = 0;
      end
      if (active && !prevActive) begin
        if (modeSel == 2'd0) begin
          chk(csLines[7:2] == 6'b111110, "R5 quad pattern", csLines, 0);
          chk(int'(csLines[1:0]) == expCh, "R7 quad channel order", csLines[1:0], expCh);
        end else begin
          chk(csLines[7:3] == 5'b11110, "R6 decoder pattern", csLines, 0);
          chk(int'(csLines[2:0]) == expCh, "R7 coded channel order", csLines[2:0], expCh);
        end
        chk(sclk == 1'b0, "R3 frame opens with sclk low", sclk, 0);
        if (gapValid)
          chk(gapCnt == 2 * ((idleGap == 0) ? 1 : int'(idleGap)) * h, "R8 idle gap length",
              gapCnt, 2 * ((idleGap == 0) ? 1 : int'(idleGap)) * h);
        frameCh  = expCh;
        frameVal = frameValue(expCh, framesStarted, w);
        framesStarted++;
        bitK = 0; riseCnt = 0; runLen = 1;
        sdi = frameVal[w-1];
      end else if (active && prevActive) begin
        if (sclk == prevSclk) runLen++;
        else begin
          chk(runLen == h, "R3 sclk phase length", runLen, h);
          runLen = 1;
          if (sclk) riseCnt++;
          else begin
            bitK++;
            if (bitK < w) sdi = frameVal[w-1-bitK];
          end
        end
      end else if (!active && prevActive) begin
        if (enSeen) begin
          chk(riseCnt == w, "R4 rising edges per frame", riseCnt, w);
          chk(runLen == h, "R3 last high phase", runLen, h);
          expRes[frameCh]  = frameVal;
          expFlag[frameCh] = 1;
          expCh = (frameCh == lastOf(modeSel, chanCount)) ? 0 : frameCh + 1;
          framesDone++;
          gapValid = 1;
          gapCnt = 1;
        end
      end else begin
        gapCnt++;
        chk(sclk == 1'b1, "R3 sclk high while idle", sclk, 1);
      end
      chk(rdValid == expFlag[rdAddr], "R10 fresh flag", rdValid, expFlag[rdAddr]);
      chk(int'(rdData) == expRes[rdAddr], "R9 stored result", rdData, expRes[rdAddr]);
      prevActive = active;
      prevSclk = sclk;
    end
    rdEnSeen = rdEn;
    rdAddrSeen = int'(rdAddr);
    enSeen = enable;
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  task automatic drive();
    @(posedge clk); #1;
  endtask

  task automatic waitFrames(input int n);
    int target;
    target = framesDone + n;
    while (framesDone < target) @(negedge clk);
  endtask

  task automatic configure(input logic [1:0] m, input logic [2:0] cc,
                           input logic [7:0] d, input logic [3:0] g);
    drive(); enable = 1'b0;
    repeat (3) drive();
    modeSel = m; chanCount = cc; clkDiv = d; idleGap = g;
    drive(); enable = 1'b1;
  endtask

  task automatic readAll();
    for (int c = 0; c < 8; c++) begin
      drive(); rdAddr = 3'(c); rdEn = 1'b1;
      drive(); rdEn = 1'b0;
    end
  endtask

  task automatic waitRise(input int n);
    do begin @(negedge clk); #1; end while (!(riseCnt == n && sclk && csLines != 8'hFF));
  endtask

  initial begin
    repeat (4) drive();
    rstN = 1'b1;
    // R1: reset state of outputs and every result slot
    for (int c = 0; c < 8; c++) begin
      drive(); rdAddr = 3'(c);
      @(negedge clk); #1;
      chk(rdValid == 1'b0 && rdData == 16'h0, "R1 reset result", {rdValid, rdData}, 0);
    end
    chk(sclk == 1'b1 && csLines == 8'hFF, "R1 reset outputs", {sclk, csLines}, 9'h1FF);

    // 16-bit framing, channels 0..2
    configure(2'd2, 3'd2, 8'd2, 4'd1);
    waitFrames(6);
    readAll();

    // R2: abort in mid frame, nothing stored, restart at channel 0
    waitRise(5);
    drive(); enable = 1'b0;
    repeat (3) drive();
    @(negedge clk); #1;
    chk(csLines == 8'hFF && sclk == 1'b1, "R2 abort leaves lines idle", {csLines, sclk}, 9'h1FF);
    drive(); enable = 1'b1;
    waitFrames(2);

    // 15-bit framing, all eight channels, zero settings act as one
    configure(2'd1, 3'd7, 8'd1, 4'd0);
    waitFrames(10);
    readAll();

    // quad 12-bit framing, chanCount capped at 3
    configure(2'd0, 3'd7, 8'd3, 4'd2);
    waitFrames(5);
    // R11: read lands on the capture edge of the same channel
    begin
      int ch;
      waitRise(12);
      ch = frameCh;
      repeat (2) @(posedge clk);
      #1; rdAddr = 3'(ch); rdEn = 1'b1;
      @(posedge clk); #1; rdEn = 1'b0;
      @(negedge clk); #1;
      chk(rdValid == 1'b1, "R11 capture wins over read", rdValid, 1);
      chk(int'(rdData) == expRes[ch], "R11 new sample shown", rdData, expRes[ch]);
      drive(); rdEn = 1'b1;
      drive(); rdEn = 1'b0;
      @(negedge clk); #1;
      chk(rdValid == 1'b0 || expFlag[ch], "R10 later read clears", rdValid, 0);
    end
    waitFrames(3);
    readAll();

    // mode value 3 behaves as 16-bit framing, single channel, divisor 0
    configure(2'd3, 3'd0, 8'd0, 4'd3);
    waitFrames(3);
    readAll();

    drive(); enable = 1'b0;
    repeat (4) drive();
    finishRun();
  end

endmodule